// File: doc/BRIEF.md
# Programmable Sample Period Generator

This block paces a sampling pipeline. It issues a sample strobe one clock cycle wide at a programmable interval. An 8-bit setting is loaded through a 16-bit write port. The setting holds a base-select bit and a 7-bit multiplier. The interval equals the chosen base unit times (multiplier + 1). The two base units are parameters that give system clock cycles per unit: a short unit and a long unit that is roughly thirty times longer. Because the units are parameters, a bench can use small values while silicon uses real counts.

The block also drives a low-rate flag, which it derives from the setting. Neighbouring logic can use this flag to lower the serial clock ceiling or to save power. Each write starts the interval again from zero. A sleep input freezes the interval count and silences the strobe while it is high. When sleep falls, the count resumes from where it stopped.

Top module: `sample_period_gen`

## Requirements
- R1: After reset the setting reads 0x0001 and low_rate is 0. The first strobe arrives in the 2·SHORT_CYCLES-th non-sleeping cycle after reset is released.
- R2: Strobes repeat every P non-sleeping cycles, where P = base × (multiplier + 1).
- R3: Bit 7 of the setting selects the base unit: 0 selects SHORT_CYCLES and 1 selects LONG_CYCLES.
- R4: Bits 6:0 of a write set the multiplier. Bits 15:8 of a write are ignored, and cfg_rdata[15:8] always reads 0. cfg_rdata[7:0] shows the stored setting from the cycle after the write.
- R5: A setting of 0x0007 gives P = 8·SHORT_CYCLES with low_rate = 0.
- R6: low_rate is 1 exactly when bit 7 is 1 or the multiplier exceeds 7.
- R7: A write restarts the interval. The strobe is low in the cycle after the write. The first new strobe appears in the P-th non-sleeping cycle after the write edge, whatever count was in progress.
- R8: The strobe is never high in two consecutive cycles.
- R9: While sleep is high the strobe stays low and the interval count holds its value. The count continues when sleep falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Setting write enable |
| cfg_wdata | input | 16 | Setting write data (bits 15:8 ignored) |
| sleep | input | 1 | Freeze interval count and mute strobe |
| cfg_rdata | output | 16 | Current setting, upper byte zero |
| sample_strobe | output | 1 | One-cycle sample strobe |
| low_rate | output | 1 | Sample rate is below the high-rate threshold |

## Verification
The hardest case to reach is sleep falling partway through an interval. Here the strobe must land after exactly the remaining number of active cycles, and a count that was cleared instead of held would show up only then. The bench drives sleep at random, cycle by cycle, during whole intervals. It counts only the cycles in which sleep is low and expects a strobe on every P-th such cycle. A directed write in the middle of an interval checks that the leftover count of the old setting never produces a strobe.

// File: rtl/spg_pkg.sv
// Package: shared setting layout and rate classification for the
// sample period generator. Assumes a 7-bit multiplier field under a
// single base-select bit.
package spg_pkg;
    localparam int MULT_W        = 7;
    localparam int SET_W         = MULT_W + 1;
    localparam int FAST_MULT_MAX = 7;  // largest short-base multiplier still at high rate

    typedef struct packed {
        logic              long_base;
        logic [MULT_W-1:0] mult;
    } spg_setting_t;

    localparam spg_setting_t SET_RESET = '{long_base: 1'b0, mult: MULT_W'(1)};

    // True when the setting yields a rate below the high-rate threshold.
    function automatic logic rate_is_low(spg_setting_t s);
        return s.long_base || (s.mult > MULT_W'(FAST_MULT_MAX));
    endfunction
endpackage

// File: rtl/spg_cfg_reg.sv
// Setting register: captures the low byte of a write, exposes it
// zero-extended, and flags the low-rate mode. Assumes the upper write
// bits carry no meaning.
module spg_cfg_reg
    import spg_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output spg_setting_t     setting,
    output logic [REG_W-1:0] rdata,
    output logic             low_rate
);
    spg_setting_t set_q;
    logic         unused_wdata_hi;

    // Hold the setting; load it on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= SET_RESET;
        end else if (we) begin
            set_q <= spg_setting_t'(wdata[SET_W-1:0]);
        end
    end

    // Expose the setting, zero-extended, and its rate class.
    always_comb begin
        setting  = set_q;
        rdata    = REG_W'(set_q);
        low_rate = rate_is_low(set_q);
    end

    assign unused_wdata_hi = ^wdata[REG_W-1:SET_W];
endmodule

// File: rtl/spg_prescaler.sv
// Prescaler: emits one tick per base unit, with the unit length chosen
// from two cycle-count parameters. Assumes both counts are at least 2.
module spg_prescaler #(
    parameter int SHORT_CYCLES = 4,
    parameter int LONG_CYCLES  = 124
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic long_base,
    output logic tick
);
    localparam int MAX_CYCLES = (LONG_CYCLES > SHORT_CYCLES) ? LONG_CYCLES : SHORT_CYCLES;
    localparam int CNT_W      = $clog2(MAX_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;

    // Pick the terminal count and flag a tick there.
    always_comb begin
        term = long_base ? CNT_W'(LONG_CYCLES - 1) : CNT_W'(SHORT_CYCLES - 1);
        tick = run && (cnt_q == term);
    end

    // Count cycles inside one base unit; clear on restart, hold when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spg_unit_counter.sv
// Unit counter: counts base-unit ticks and raises the strobe on the
// (multiplier + 1)-th tick. Assumes ticks never come in adjacent cycles.
module spg_unit_counter #(
    parameter int MULT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tick,
    input  logic [MULT_W-1:0] mult,
    output logic              strobe
);
    logic [MULT_W-1:0] units_q;

    // Strobe on the tick that completes the last unit.
    assign strobe = tick && (units_q == mult);

    // Advance the unit count per tick; wrap after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            units_q <= '0;
        end else if (tick) begin
            units_q <= strobe ? '0 : units_q + 1'b1;
        end
    end
endmodule

// File: rtl/sample_period_gen.sv
// Top: programmable sample period generator. The period is the selected
// base unit times (multiplier + 1). A write restarts the interval and
// sleep freezes it. Assumes SHORT_CYCLES and LONG_CYCLES are both >= 2.
module sample_period_gen
    import spg_pkg::*;
#(
    parameter int SHORT_CYCLES = 4,
    parameter int LONG_CYCLES  = 124,
    parameter int REG_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             sleep,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             sample_strobe,
    output logic             low_rate
);
    spg_setting_t setting;
    logic         tick;

    spg_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .setting  (setting),
        .rdata    (cfg_rdata),
        .low_rate (low_rate)
    );

    spg_prescaler #(.SHORT_CYCLES(SHORT_CYCLES), .LONG_CYCLES(LONG_CYCLES)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (cfg_we),
        .run       (!sleep),
        .long_base (setting.long_base),
        .tick      (tick)
    );

    spg_unit_counter #(.MULT_W(MULT_W)) u_units (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_we),
        .tick    (tick),
        .mult    (setting.mult),
        .strobe  (sample_strobe)
    );
endmodule

// File: rtl/spg_checker.sv
// Checker: temporal properties of the sample period generator, bound
// onto every instance of the top module.
module spg_checker #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [REG_W-1:0] cfg_wdata,
    input logic             sleep,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             sample_strobe,
    input logic             low_rate
);
    // Reset value shows once reset is released.
    assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cfg_rdata == REG_W'(16'h0001));

    // The setting changes only on a write.
    assert_hold_setting_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

    // A write lands in the low byte on the next cycle.
    assert_write_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata[7:0] == $past(cfg_wdata[7:0]));

    // The upper byte reads as zero.
    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[REG_W-1:8] == '0);

    // The rate flag follows the stored fields.
    assert_low_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        low_rate == (cfg_rdata[7] || (cfg_rdata[6:0] > 7'd7)));

    // A write restarts the interval, so no strobe follows at once.
    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !sample_strobe);

    // The strobe lasts a single cycle.
    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> !sample_strobe);

    // Sleep mutes the strobe.
    assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !sample_strobe);
endmodule

bind sample_period_gen spg_checker #(.REG_W(REG_W)) u_spg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .sleep         (sleep),
    .cfg_rdata     (cfg_rdata),
    .sample_strobe (sample_strobe),
    .low_rate      (low_rate)
);

// File: tb/sample_period_gen_test.sv
module sample_period_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int SHORT      = 3;
    localparam int LONG       = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        sleep = 1'b0;
    logic [15:0] cfg_rdata;
    logic        sample_strobe;
    logic        low_rate;
    int          checks = 0;
    int          fails = 0;

    sample_period_gen #(.SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .sleep(sleep), .cfg_rdata(cfg_rdata), .sample_strobe(sample_strobe),
        .low_rate(low_rate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_period(logic [15:0] v);
        return (v[7] ? LONG : SHORT) * (int'(v[6:0]) + 1);
    endfunction

    function automatic logic exp_low(logic [15:0] v);
        return v[7] || (v[6:0] > 7'd7);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Each slot runs from one falling edge to the next. The strobe is
    // expected on every P-th slot in which sleep is low.
    task automatic run_slots(int p, int target, int sleep_pct, string req);
        int active = 0;
        int guard = 0;
        int bad_slot = -1;
        int bad_act = 0;
        int bad_exp = 0;
        logic exp;
        while (active < target && guard < 20000) begin
            sleep = ($urandom_range(99) < sleep_pct);
            #1;
            if (!sleep) active++;
            exp = !sleep && (active % p == 0);
            if (sample_strobe !== exp && bad_slot < 0) begin
                bad_slot = active;
                bad_act = int'(sample_strobe);
                bad_exp = int'(exp);
            end
            @(negedge clk);
            guard++;
        end
        sleep = 1'b0;
        check(bad_slot < 0 && active == target, req, $sformatf("strobe at active slot %0d", bad_slot),
              bad_act, bad_exp);
    endtask

    task automatic write_cfg(logic [15:0] v);
        cfg_wdata = v;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_and_check(logic [15:0] v, int sleep_pct, string req);
        write_cfg(v);
        check(cfg_rdata == {8'h00, v[7:0]}, "R4", "readback", int'(cfg_rdata), int'({8'h00, v[7:0]}));
        check(low_rate == exp_low(v), "R6", "low_rate", int'(low_rate), int'(exp_low(v)));
        run_slots(exp_period(v), 2 * exp_period(v), sleep_pct, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset value, flag and first intervals
        check(cfg_rdata == 16'h0001, "R1", "reset readback", int'(cfg_rdata), 1);
        check(low_rate == 1'b0, "R1", "reset low_rate", int'(low_rate), 0);
        run_slots(2 * SHORT, 4 * SHORT, 0, "R1");

        // R5: eight short units, high rate
        write_and_check(16'h0007, 0, "R5");
        // R4: upper byte of the write ignored
        write_and_check(16'hAB07, 0, "R4");
        // R6 boundary: first low-rate multiplier
        write_and_check(16'h0008, 0, "R6");
        // R2: smallest period
        write_and_check(16'h0000, 0, "R2");
        // R3: long base, multiplier 0
        write_and_check(16'h0080, 0, "R3");
        // R3: longest period
        write_and_check(16'h00FF, 0, "R3");
        // R9: random sleep throughout the intervals
        write_and_check(16'h0003, 40, "R9");
        write_and_check(16'h0085, 30, "R9");

        // R7: restart in the middle of an interval
        write_cfg(16'h0005);
        run_slots(exp_period(16'h0005), 7, 0, "R7");
        write_cfg(16'h0002);
        check(sample_strobe == 1'b0, "R7", "strobe after write", int'(sample_strobe), 0);
        run_slots(exp_period(16'h0002), 2 * exp_period(16'h0002), 0, "R7");

        // R2 and R8: random settings, some with sleep
        for (int i = 0; i < 10; i++) begin
            logic [15:0] v;
            v = 16'($urandom);
            if (v[7]) v[6:0] = v[6:0] & 7'h1F;
            write_and_check(v, (i % 3 == 0) ? 25 : 0, "R2");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule